// File: doc/BRIEF.md
# Transparent Cyclic Byte Transmitter

This block drives a one-bit serial line from a small byte buffer with no framing at all. No flag is added, no checksum is computed and no bit stuffing is applied. Software loads between 1 and 32 bytes through a write port and then issues a transmit command. The block first sends a single all-ones sync byte. It then shifts the stored bytes onto the line, least significant bit first. A bit advances only in a cycle where the bit-enable input is high.

The transmit command can carry a repeat flag. With the flag set, the loaded bytes are sent again and again, and the sync byte is not repeated between passes. Repetition ends on a reset command, or on any command write whose repeat flag is clear. After that the line rests at logic 1 and the buffer is empty. A one-shot send also empties the buffer once its last bit has gone out.

Top module: `xparent_cyclic_tx`

## Requirements
- R1: After reset, tx_bit is 1, tx_active is 0 and the buffer is empty.
- R2: A transmit command on a non-empty buffer raises tx_active one cycle later. The line then carries 8 ones (sync 0xFF), followed by every stored byte in write order, each least significant bit first. Each bit is held until a cycle with bit_en high consumes it. After the last bit of a one-shot send, tx_active falls and tx_bit is 1.
- R3: Data goes out raw. Bytes such as 0x7E and runs of 0xFF appear on the line unchanged, with no inserted zeros, flags or checksum bits.
- R4: A transmit command while the buffer is empty is ignored, and tx_active stays 0.
- R5: The buffer holds 32 bytes. A write made while it is full is dropped.
- R6: A transmit command with cmd_repeat=1 sends the sync byte once and then sends the stored bytes in an endless loop. A further command with cmd_repeat=1 during the loop leaves the stream undisturbed.
- R7: During a repeat loop, a command write with cmd_repeat=0 stops output in the next cycle: tx_active becomes 0, tx_bit becomes 1 and the buffer is emptied.
- R8: A command write with cmd_reset=1 takes priority over all other command bits. It stops any transmission in the next cycle and empties the buffer.
- R9: A completed one-shot send leaves the buffer empty, so a following transmit command is ignored.
- R10: Byte writes made while tx_active is 1 are dropped.
- R11: A repeat loop over a single stored byte resends that byte with no gap and no sync.
- R12: A transmit command while a send is in progress does not restart or change the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the buffer |
| wr_data | input | 8 | Byte to write |
| cmd_valid | input | 1 | Command write strobe |
| cmd_xmit | input | 1 | Command bit: start transmission |
| cmd_repeat | input | 1 | Command bit: loop the buffer (must stay set to keep looping) |
| cmd_reset | input | 1 | Command bit: stop and empty the buffer |
| bit_en | input | 1 | Serial bit clock enable |
| tx_bit | output | 1 | Serial line output |
| tx_active | output | 1 | High while the sync byte or buffer data is being sent |

## Verification
The bench checks the wrap from the last byte back to the first. A design that re-sent the sync byte there, or skipped byte 0, breaks the bit stream, and so does a one-byte loop that idles for a byte. It fills the buffer past 32 entries and checks that exactly 32 bytes are sent; an off-by-one full test adds or drops a byte. It writes bytes and repeats the transmit command in mid-send, which catches a design that restarts or extends the stream. It also ends loops with a repeat-clear write and with a reset command, then issues a transmit command. A design that keeps stale buffer contents would start sending again.

// File: rtl/xct_pkg.sv
package xct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } xct_state_e;
endpackage

// File: rtl/xct_buffer.sv
module xct_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] fill_n;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[fill_cnt[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  always_comb begin
    fill_n = fill_cnt;
    if (clr) begin
      fill_n = '0;
    end else if (wr_ok) begin
      fill_n = fill_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else begin
      fill_cnt <= fill_n;
    end
  end
endmodule

// File: rtl/xct_serializer.sv
module xct_serializer #(
  parameter int DW  = 8,
  localparam int BW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_sync,
  input  logic          load_data,
  input  logic          shift,
  input  logic [DW-1:0] par_in,
  output logic          ser_out,
  output logic          last_bit
);
  logic [DW-1:0] sh_q, sh_n;
  logic [BW-1:0] bcnt_q, bcnt_n;

  always_comb begin
    sh_n   = sh_q;
    bcnt_n = bcnt_q;
    if (load_sync) begin
      sh_n   = '1;
      bcnt_n = '0;
    end else if (load_data) begin
      sh_n   = par_in;
      bcnt_n = '0;
    end else if (shift) begin
      sh_n   = {1'b1, sh_q[DW-1:1]};
      bcnt_n = bcnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bcnt_q <= '0;
    end else begin
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
    end
  end

  assign ser_out  = sh_q[0];
  assign last_bit = (bcnt_q == BW'(DW - 1));
endmodule

// File: rtl/xct_sequencer.sv
module xct_sequencer
  import xct_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_xmit,
  input  logic          cmd_repeat,
  input  logic          cmd_reset,
  input  logic          bit_en,
  input  logic [CW-1:0] fill_cnt,
  input  logic          last_bit,
  output logic          start,
  output logic          load_sync,
  output logic          load_data,
  output logic          shift,
  output logic          buf_clr,
  output logic [AW-1:0] rd_addr,
  output logic          active,
  output logic          rep_mode
);
  xct_state_e    st_q, st_n;
  logic [CW-1:0] idx_q, idx_n;
  logic          rep_n;
  logic          wrap;
  logic          stop;

  assign active = (st_q != ST_IDLE);
  assign wrap   = (idx_q == fill_cnt);
  assign stop   = cmd_valid && (cmd_reset || (active && rep_mode && !cmd_repeat));

  always_comb begin
    st_n      = st_q;
    idx_n     = idx_q;
    rep_n     = rep_mode;
    start     = 1'b0;
    load_sync = 1'b0;
    load_data = 1'b0;
    shift     = 1'b0;
    buf_clr   = 1'b0;
    rd_addr   = wrap ? '0 : idx_q[AW-1:0];
    if (stop) begin
      st_n    = ST_IDLE;
      rep_n   = 1'b0;
      buf_clr = 1'b1;
    end else if (cmd_valid && cmd_xmit && !active && (fill_cnt != '0)) begin
      start     = 1'b1;
      load_sync = 1'b1;
      st_n      = ST_SYNC;
      idx_n     = '0;
      rep_n     = cmd_repeat;
    end else if (active && bit_en) begin
      if (!last_bit) begin
        shift = 1'b1;
      end else if (!wrap) begin
        load_data = 1'b1;
        idx_n     = idx_q + CW'(1);
        st_n      = ST_DATA;
      end else if (rep_mode) begin
        load_data = 1'b1;
        idx_n     = CW'(1);
        st_n      = ST_DATA;
      end else begin
        st_n    = ST_IDLE;
        buf_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      rep_mode <= 1'b0;
    end else begin
      st_q     <= st_n;
      idx_q    <= idx_n;
      rep_mode <= rep_n;
    end
  end
endmodule

// File: rtl/xparent_cyclic_tx.sv
module xparent_cyclic_tx #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_valid,
  input  logic          cmd_xmit,
  input  logic          cmd_repeat,
  input  logic          cmd_reset,
  input  logic          bit_en,
  output logic          tx_bit,
  output logic          tx_active
);
  logic [CW-1:0] fill_cnt;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          start, load_sync, load_data, shift, buf_clr;
  logic          active, rep_mode, ser_out, last_bit, wr_ok;

  assign wr_ok = wr_en && !active && !start && !buf_clr && (fill_cnt != CW'(DEPTH));

  xct_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .wr_data  (wr_data),
    .clr      (buf_clr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .fill_cnt (fill_cnt)
  );

  xct_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_xmit   (cmd_xmit),
    .cmd_repeat (cmd_repeat),
    .cmd_reset  (cmd_reset),
    .bit_en     (bit_en),
    .fill_cnt   (fill_cnt),
    .last_bit   (last_bit),
    .start      (start),
    .load_sync  (load_sync),
    .load_data  (load_data),
    .shift      (shift),
    .buf_clr    (buf_clr),
    .rd_addr    (rd_addr),
    .active     (active),
    .rep_mode   (rep_mode)
  );

  xct_serializer #(.DW(DW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_sync (load_sync),
    .load_data (load_data),
    .shift     (shift),
    .par_in    (rd_data),
    .ser_out   (ser_out),
    .last_bit  (last_bit)
  );

  assign tx_bit    = active ? ser_out : 1'b1;
  assign tx_active = active;
endmodule

// File: rtl/xct_checker.sv
module xct_checker #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_xmit,
  input logic          cmd_repeat,
  input logic          cmd_reset,
  input logic          bit_en,
  input logic          tx_bit,
  input logic          tx_active,
  input logic          rep_mode,
  input logic [CW-1:0] fill_cnt
);
  assert_reset_cmd_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_reset) |=> (!tx_active && fill_cnt == '0));

  assert_clear_repeat_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_reset && !cmd_repeat && tx_active && rep_mode) |=> !tx_active);

  assert_start_needs_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(cmd_valid && cmd_xmit && fill_cnt != '0));

  assert_sync_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> tx_bit);

  assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !bit_en && !cmd_valid) |=> $stable(tx_bit));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  assert_loop_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && rep_mode && !cmd_valid) |=> tx_active);

  assert_no_write_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> (fill_cnt <= $past(fill_cnt)));
endmodule

bind xparent_cyclic_tx xct_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_xmit   (cmd_xmit),
  .cmd_repeat (cmd_repeat),
  .cmd_reset  (cmd_reset),
  .bit_en     (bit_en),
  .tx_bit     (tx_bit),
  .tx_active  (tx_active),
  .rep_mode   (rep_mode),
  .fill_cnt   (fill_cnt)
);

// File: tb/tb_xparent_cyclic_tx.sv
module tb_xparent_cyclic_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, wr_en, cmd_valid, cmd_xmit, cmd_repeat, cmd_reset, bit_en;
  logic [7:0] wr_data;
  logic tx_bit, tx_active;

  int checks = 0;
  int fails  = 0;
  int ben_cnt = 0;
  bit mon_off = 1'b0;
  string cur_req = "R2";
  logic exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xparent_cyclic_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_xmit(cmd_xmit), .cmd_repeat(cmd_repeat),
    .cmd_reset(cmd_reset), .bit_en(bit_en), .tx_bit(tx_bit), .tx_active(tx_active)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // bit enable: one cycle in three
  always @(negedge clk) begin
    if (ben_cnt == 2) begin
      ben_cnt = 0;
      bit_en  = 1'b1;
    end else begin
      ben_cnt++;
      bit_en  = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && !mon_off && bit_en && tx_active) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s extra bit: actual %0b expected none", cur_req, tx_bit);
      end else begin
        chk(cur_req, {31'd0, tx_bit}, {31'd0, exp_q.pop_front()}, "line bit");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic push_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic wr_byte(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(logic x, logic r, logic s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_xmit = x; cmd_repeat = r; cmd_reset = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_xmit = 1'b0; cmd_repeat = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic check_idle(string req);
    repeat (3) @(negedge clk);
    #2;
    chk(req, {31'd0, tx_active}, 32'd0, "tx_active idle");
    chk(req, {31'd0, tx_bit}, 32'd1, "line idle high");
  endtask

  task automatic check_ignored(string req);
    cmd(1'b1, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    #2;
    chk(req, {31'd0, tx_active}, 32'd0, "transmit ignored");
  endtask

  task automatic wait_empty();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] bytes33 [33];
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bit_en = 1'b0;
    cmd_valid = 1'b0; cmd_xmit = 1'b0; cmd_repeat = 1'b0; cmd_reset = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", {31'd0, tx_bit}, 32'd1, "reset line");
    chk("R1", {31'd0, tx_active}, 32'd0, "reset active");

    // R4 / R1: buffer empty after reset
    check_ignored("R4");

    // R2: one-shot with sync byte
    cur_req = "R2";
    wr_byte(8'hA5); wr_byte(8'h3C); wr_byte(8'h81);
    push_byte(8'hFF); push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h81);
    cmd(1'b1, 1'b0, 1'b0);
    wait_empty();
    check_idle("R2");
    check_ignored("R9");

    // R3: raw flag pattern and long ones runs
    cur_req = "R3";
    wr_byte(8'h7E); wr_byte(8'hFF); wr_byte(8'hFF); wr_byte(8'h00);
    push_byte(8'hFF); push_byte(8'h7E); push_byte(8'hFF); push_byte(8'hFF); push_byte(8'h00);
    cmd(1'b1, 1'b0, 1'b0);
    wait_empty();
    check_idle("R3");

    // R10 / R12: writes and transmit commands mid-send are ignored
    cur_req = "R12";
    wr_byte(8'h12); wr_byte(8'hC7);
    push_byte(8'hFF); push_byte(8'h12); push_byte(8'hC7);
    cmd(1'b1, 1'b0, 1'b0);
    wait (exp_q.size() < 12);
    wr_byte(8'h55);
    cmd(1'b1, 1'b0, 1'b0);
    wait_empty();
    check_idle("R12");
    check_ignored("R10");

    // R5: 33 writes, only 32 kept
    cur_req = "R5";
    for (int i = 0; i < 33; i++) bytes33[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int i = 0; i < 33; i++) wr_byte(bytes33[i]);
    push_byte(8'hFF);
    for (int i = 0; i < 32; i++) push_byte(bytes33[i]);
    cmd(1'b1, 1'b0, 1'b0);
    wait_empty();
    check_idle("R5");

    // R6 / R7: repeat loop, keep-alive, stop by repeat-clear write
    cur_req = "R6";
    wr_byte(8'h0F); wr_byte(8'hB2); wr_byte(8'h6D);
    push_byte(8'hFF);
    for (int p = 0; p < 3; p++) begin
      push_byte(8'h0F); push_byte(8'hB2); push_byte(8'h6D);
    end
    cmd(1'b1, 1'b1, 1'b0);
    wait (exp_q.size() < 40);
    cmd(1'b1, 1'b1, 1'b0);
    wait_empty();
    cur_req = "R7";
    cmd(1'b0, 1'b0, 1'b0);
    check_idle("R7");
    check_ignored("R7");

    // R11 / R8: single-byte loop, stopped by reset command
    cur_req = "R11";
    wr_byte(8'h9A);
    push_byte(8'hFF);
    for (int p = 0; p < 4; p++) push_byte(8'h9A);
    cmd(1'b1, 1'b1, 1'b0);
    wait_empty();
    cur_req = "R8";
    cmd(1'b1, 1'b1, 1'b1);
    check_idle("R8");
    check_ignored("R8");

    // R8: reset command during a one-shot send
    cur_req = "R8";
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
    push_byte(8'hFF); push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_byte(8'h44);
    cmd(1'b1, 1'b0, 1'b0);
    wait (exp_q.size() < 20);
    @(negedge clk);
    mon_off = 1'b1;
    cmd(1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    exp_q.delete();
    mon_off = 1'b0;
    check_idle("R8");
    check_ignored("R8");

    finish_run();
  end
endmodule